// File: doc/BRIEF.md
# Transmit Packet Interface Rule Checker

This block taps the per-cycle control fields of a wide transmit user interface. Each cycle carries up to four 64-bit words. The block checks each cycle against the interface's protocol rules and reports how many bytes the cycle carried. The fields it observes are:

- a 3-bit word count;
- an 8-bit channel number;
- burst start and end markers;
- a packet start marker;
- a 4-bit end code.

The end code combines an end-of-packet flag in its top bit with the byte count of the last word in its low three bits. The block keeps an open-packet bit for each of the 256 channels. It uses those bits to catch a packet that starts twice or ends without having started, while packets on different channels interleave at burst boundaries.

The tap is a pure observer and never stalls the bus, so it has no ready signal. A cycle counts as carrying data when its word count is not zero. The result stream comes out one cycle after each observed cycle:

- `res_valid` marks a data cycle.
- `res_bytes` gives that cycle's byte count.
- A set of error flags reports any rule the cycle broke.

The flags stay low in cycles that break no rule. The consumer must take each result in the cycle it appears.

Top module: `txif_rule_checker`

## Requirements
- R1: For a cycle with a word count W in 1..4, the result one cycle later has res_valid=1 and res_bytes = 8*(W-1) + L. L is the low three bits of the end code when the end code's bit 3 is set, with 0 meaning 8. L is 8 when bit 3 is clear.
- R2: For a cycle with word count 0, the result has res_valid=0 and res_bytes=0. If that cycle has a packet start, a burst start, a burst end or a nonzero end code, err_idle_mark is raised.
- R3: A word count of 5, 6 or 7 raises err_words with res_valid=1 and res_bytes=0. Such a cycle changes no packet or burst state.
- R4: A nonzero end code with bit 3 clear raises err_code, and the cycle is not treated as a packet end.
- R5: In the cycle right after a data cycle that had a packet start, a channel value that differs from that start cycle's channel raises err_hold. This applies even when the second cycle carries no data.
- R6: After a data cycle without a burst end, the next data cycle must use the same channel, or err_switch is raised. A data cycle with a burst end closes the burst, so a channel change after it raises no error even while packets on other channels are still open.
- R7: A packet start on a channel whose packet is already open raises err_sop_open. A packet end on a channel that is neither open nor starting in the same cycle raises err_eop_closed.
- R8: In a data cycle with a valid word count, a packet end closes the channel's packet. A start without an end opens it. A start and end in the same cycle leaves the packet closed. All 256 channels are closed after reset.
- R9: While reset is asserted and in the first cycle after it, every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sym_words | input | 3 | Number of 64-bit words holding data this cycle |
| sym_chan | input | 8 | Logical channel of this cycle |
| sym_sob | input | 1 | Burst start marker |
| sym_eob | input | 1 | Burst end marker |
| sym_sop | input | 1 | Packet start marker |
| sym_eop_code | input | 4 | Bit 3 = packet end; bits 2:0 = bytes in last word (0 = 8) |
| res_valid | output | 1 | Result belongs to a data cycle |
| res_bytes | output | 6 | Bytes carried by the observed cycle |
| err_idle_mark | output | 1 | Marker present in a cycle without data |
| err_words | output | 1 | Word count above four |
| err_code | output | 1 | Malformed end code |
| err_hold | output | 1 | Channel not held after a packet start |
| err_switch | output | 1 | Channel changed inside a burst |
| err_sop_open | output | 1 | Packet start on an already open channel |
| err_eop_closed | output | 1 | Packet end on a closed channel |

## Verification
The assertions check, on every cycle:

- that a start accepted on a channel leaves that channel open;
- that an end leaves it closed;
- that an idle result reports zero bytes;
- that a valid-count result stays within 1 to 32 bytes;
- that a hold error only follows a data cycle with a packet start.

Only the bench scenarios can show other behaviours. These include the exact byte value for each word count and end code, and the interleaving of packets across channels over long random runs. They also include the absence of false errors when the channel changes at a burst boundary, and the correct open or closed state of a channel many cycles later.

// File: rtl/txif_chk_pkg.sv
package txif_chk_pkg;
  localparam int WORD_BYTES = 8;
  localparam int MAX_WORDS  = 4;
  localparam int CNT_W      = 3;
  localparam int BYTE_W     = $clog2(WORD_BYTES * MAX_WORDS + 1);

  typedef struct packed {
    logic              active;     // word count within 1..MAX_WORDS
    logic              has_data;   // word count nonzero
    logic              eop;        // well-formed packet end
    logic              idle_err;
    logic              range_err;
    logic              code_err;
    logic [BYTE_W-1:0] bytes;
  } sym_info_t;
endpackage

// File: rtl/txif_sym_decode.sv
module txif_sym_decode
  import txif_chk_pkg::*;
(
  input  logic [CNT_W-1:0] words,
  input  logic             sob,
  input  logic             eob,
  input  logic             sop,
  input  logic [3:0]       eop_code,
  output sym_info_t        info
);
  logic [BYTE_W-1:0] full_part;
  logic [BYTE_W-1:0] last_part;
  logic              code_end;

  always_comb begin
    code_end  = eop_code[3];
    full_part = BYTE_W'({words - CNT_W'(1), 3'b000});
    if (code_end && (eop_code[2:0] != 3'd0))
      last_part = BYTE_W'(eop_code[2:0]);
    else
      last_part = BYTE_W'(WORD_BYTES);

    info.has_data  = (words != '0);
    info.range_err = (words > CNT_W'(MAX_WORDS));
    info.active    = info.has_data && !info.range_err;
    info.idle_err  = !info.has_data && (sob || eob || sop || (eop_code != 4'd0));
    info.code_err  = !code_end && (eop_code[2:0] != 3'd0);
    info.eop       = info.active && code_end;
    info.bytes     = info.active ? (full_part + last_part) : '0;
  end
endmodule

// File: rtl/txif_chan_tracker.sv
module txif_chan_tracker #(
  parameter int CHANS  = 256,
  parameter int CHAN_W = $clog2(CHANS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              upd_en,
  input  logic [CHAN_W-1:0] chan,
  input  logic              sop,
  input  logic              eop,
  output logic              sop_open_err,
  output logic              eop_closed_err
);
  logic [CHANS-1:0] open_q;
  logic             cur_open;

  assign cur_open       = open_q[chan];
  assign sop_open_err   = upd_en && sop && cur_open;
  assign eop_closed_err = upd_en && eop && !sop && !cur_open;

  for (genvar i = 0; i < CHANS; i++) begin : g_entry
    always_ff @(posedge clk) begin
      if (!rst_n)
        open_q[i] <= 1'b0;
      else if (upd_en && (chan == CHAN_W'(i))) begin
        if (eop)
          open_q[i] <= 1'b0;
        else if (sop)
          open_q[i] <= 1'b1;
      end
    end
  end

  AST_SOP_OPENS: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_en && sop && !eop) |=> open_q[$past(chan)]) else $error("open failed"); // R8
  AST_EOP_CLOSES: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_en && eop) |=> !open_q[$past(chan)]) else $error("close failed"); // R8
endmodule

// File: rtl/txif_order_check.sv
module txif_order_check #(
  parameter int CHAN_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              active,
  input  logic [CHAN_W-1:0] chan,
  input  logic              sop,
  input  logic              eob,
  output logic              hold_err,
  output logic              switch_err
);
  logic              sop_seen_q;
  logic [CHAN_W-1:0] sop_chan_q;
  logic              burst_open_q;
  logic [CHAN_W-1:0] burst_chan_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sop_seen_q   <= 1'b0;
      sop_chan_q   <= '0;
      burst_open_q <= 1'b0;
      burst_chan_q <= '0;
    end else begin
      sop_seen_q <= active && sop;
      sop_chan_q <= chan;
      if (active) begin
        burst_open_q <= !eob;
        burst_chan_q <= chan;
      end
    end
  end

  assign hold_err   = sop_seen_q && (chan != sop_chan_q);
  assign switch_err = active && burst_open_q && (chan != burst_chan_q);
endmodule

// File: rtl/txif_rule_checker.sv
module txif_rule_checker
  import txif_chk_pkg::*;
#(
  parameter int CHANS  = 256,
  parameter int CHAN_W = $clog2(CHANS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2:0]        sym_words,
  input  logic [CHAN_W-1:0] sym_chan,
  input  logic              sym_sob,
  input  logic              sym_eob,
  input  logic              sym_sop,
  input  logic [3:0]        sym_eop_code,
  output logic              res_valid,
  output logic [5:0]        res_bytes,
  output logic              err_idle_mark,
  output logic              err_words,
  output logic              err_code,
  output logic              err_hold,
  output logic              err_switch,
  output logic              err_sop_open,
  output logic              err_eop_closed
);
  sym_info_t info;
  logic      sop_open_c, eop_closed_c, hold_c, switch_c;

  txif_sym_decode u_dec (
    .words    (sym_words),
    .sob      (sym_sob),
    .eob      (sym_eob),
    .sop      (sym_sop),
    .eop_code (sym_eop_code),
    .info     (info)
  );

  txif_chan_tracker #(.CHANS(CHANS), .CHAN_W(CHAN_W)) u_trk (
    .clk            (clk),
    .rst_n          (rst_n),
    .upd_en         (info.active),
    .chan           (sym_chan),
    .sop            (sym_sop),
    .eop            (info.eop),
    .sop_open_err   (sop_open_c),
    .eop_closed_err (eop_closed_c)
  );

  txif_order_check #(.CHAN_W(CHAN_W)) u_ord (
    .clk        (clk),
    .rst_n      (rst_n),
    .active     (info.active),
    .chan       (sym_chan),
    .sop        (sym_sop),
    .eob        (sym_eob),
    .hold_err   (hold_c),
    .switch_err (switch_c)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_valid      <= 1'b0;
      res_bytes      <= '0;
      err_idle_mark  <= 1'b0;
      err_words      <= 1'b0;
      err_code       <= 1'b0;
      err_hold       <= 1'b0;
      err_switch     <= 1'b0;
      err_sop_open   <= 1'b0;
      err_eop_closed <= 1'b0;
    end else begin
      res_valid      <= info.has_data;
      res_bytes      <= 6'(info.bytes);
      err_idle_mark  <= info.idle_err;
      err_words      <= info.range_err;
      err_code       <= info.code_err;
      err_hold       <= hold_c;
      err_switch     <= switch_c;
      err_sop_open   <= sop_open_c;
      err_eop_closed <= eop_closed_c;
    end
  end

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !res_valid |-> (res_bytes == 6'd0)) else $error("idle bytes"); // R2
  AST_BYTES_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !err_words) |-> (res_bytes >= 6'd1 && res_bytes <= 6'd32)) else $error("byte range"); // R1
  AST_HOLD_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    err_hold |-> ($past(sym_sop, 2) && ($past(sym_words, 2) != 3'd0))) else $error("hold cause"); // R5
endmodule

// File: tb/txif_rule_checker_test.sv
module txif_rule_checker_test;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [2:0] sym_words;
  logic [7:0] sym_chan;
  logic       sym_sob, sym_eob, sym_sop;
  logic [3:0] sym_eop_code;
  logic       res_valid;
  logic [5:0] res_bytes;
  logic       err_idle_mark, err_words, err_code, err_hold, err_switch, err_sop_open, err_eop_closed;

  int tests = 0;
  int fails = 0;
  bit done = 0;

  // model state
  bit [255:0] m_open;
  bit         m_sop_seen;
  bit [7:0]   m_sop_chan;
  bit         m_burst;
  bit [7:0]   m_burst_chan;

  always #10 clk = ~clk;

  txif_rule_checker uut (
    .clk(clk), .rst_n(rst_n), .sym_words(sym_words), .sym_chan(sym_chan),
    .sym_sob(sym_sob), .sym_eob(sym_eob), .sym_sop(sym_sop), .sym_eop_code(sym_eop_code),
    .res_valid(res_valid), .res_bytes(res_bytes), .err_idle_mark(err_idle_mark),
    .err_words(err_words), .err_code(err_code), .err_hold(err_hold), .err_switch(err_switch),
    .err_sop_open(err_sop_open), .err_eop_closed(err_eop_closed)
  );

  task automatic chk(string req, string what, int act, int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int exp_bytes(int w, bit [3:0] code);
    int last;
    if (w < 1 || w > 4) return 0;
    if (code[3]) last = (code[2:0] == 0) ? 8 : int'(code[2:0]);
    else last = 8;
    return 8 * (w - 1) + last;
  endfunction

  task automatic cyc(int w, int ch, bit sob, bit eob, bit sop, bit [3:0] code);
    bit act, dat, eop, e_idle, e_rng, e_code, e_hold, e_sw, e_so, e_ec;
    @(negedge clk);
    sym_words = 3'(w); sym_chan = 8'(ch); sym_sob = sob; sym_eob = eob;
    sym_sop = sop; sym_eop_code = code;
    dat    = (w != 0);
    act    = (w >= 1 && w <= 4);
    eop    = act && code[3];
    e_idle = !dat && (sob || eob || sop || code != 0);
    e_rng  = (w > 4);
    e_code = !code[3] && code[2:0] != 0;
    e_hold = m_sop_seen && (8'(ch) != m_sop_chan);
    e_sw   = act && m_burst && (8'(ch) != m_burst_chan);
    e_so   = act && sop && m_open[ch];
    e_ec   = act && eop && !sop && !m_open[ch];
    m_sop_seen = act && sop;
    m_sop_chan = 8'(ch);
    if (act) begin
      m_burst = !eob; m_burst_chan = 8'(ch);
      if (eop) m_open[ch] = 1'b0;
      else if (sop) m_open[ch] = 1'b1;
    end
    @(posedge clk); #5;
    chk("R1", "res_valid", int'(res_valid), int'(dat));
    chk("R1", "res_bytes", int'(res_bytes), exp_bytes(w, code));
    chk("R2", "err_idle_mark", int'(err_idle_mark), int'(e_idle));
    chk("R3", "err_words", int'(err_words), int'(e_rng));
    chk("R4", "err_code", int'(err_code), int'(e_code));
    chk("R5", "err_hold", int'(err_hold), int'(e_hold));
    chk("R6", "err_switch", int'(err_switch), int'(e_sw));
    chk("R7", "err_sop_open", int'(err_sop_open), int'(e_so));
    chk("R7", "err_eop_closed", int'(err_eop_closed), int'(e_ec));
  endtask

  initial begin
    #3_000_000;
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    rst_n = 1'b0; sym_words = '0; sym_chan = '0; sym_sob = 0; sym_eob = 0;
    sym_sop = 0; sym_eop_code = '0;
    m_open = '0; m_sop_seen = 0; m_sop_chan = '0; m_burst = 0; m_burst_chan = '0;
    repeat (3) @(posedge clk);
    #5;
    chk("R9", "reset res_valid", int'(res_valid), 0);
    chk("R9", "reset bytes", int'(res_bytes), 0);
    chk("R9", "reset flags", int'({err_idle_mark, err_words, err_code, err_hold,
                                    err_switch, err_sop_open, err_eop_closed}), 0);
    @(negedge clk); rst_n = 1'b1;

    // R1 single word packet ending with 3 bytes, then full 4-word packet
    cyc(1, 5, 1, 1, 1, 4'b1011);
    cyc(4, 5, 1, 1, 1, 4'b1000);
    // R8 packet spanning bursts, interleaved with another channel at boundaries
    cyc(2, 7, 1, 0, 1, 4'b0000);
    cyc(3, 7, 0, 1, 0, 4'b0000);
    cyc(4, 9, 1, 1, 1, 4'b0000);   // R6 switch after burst end, no error
    cyc(1, 7, 1, 1, 0, 4'b1110);   // R8 closes channel 7
    cyc(1, 9, 1, 1, 0, 4'b1001);   // closes channel 9
    // R7 end on closed channel, start on open channel
    cyc(1, 7, 1, 1, 0, 4'b1000);
    cyc(2, 255, 1, 1, 1, 4'b0000);
    cyc(2, 255, 1, 1, 1, 4'b0000); // R7 sop on open (channel 255)
    cyc(1, 255, 1, 1, 0, 4'b1101);
    // R5 hold violation in an idle follow-up cycle
    cyc(2, 20, 1, 0, 1, 4'b0000);
    cyc(0, 21, 0, 0, 0, 4'b0000);
    cyc(2, 20, 0, 1, 0, 4'b1000);
    // R6 switch inside a burst
    cyc(2, 30, 1, 0, 1, 4'b0000);
    cyc(1, 30, 0, 0, 0, 4'b0000);
    cyc(1, 31, 0, 1, 0, 4'b0000);
    cyc(1, 30, 1, 1, 0, 4'b1000);
    // R2 idle markers, R3 range, R4 bad code
    cyc(0, 0, 0, 0, 1, 4'b0000);
    cyc(0, 0, 0, 0, 0, 4'b1000);
    cyc(6, 40, 1, 1, 1, 4'b0000);  // R3 no state change: sop below is clean
    cyc(1, 40, 1, 1, 1, 4'b0011);  // R4: not an end, so channel 40 opens
    cyc(1, 40, 1, 1, 0, 4'b1000);

    // random traffic
    for (int i = 0; i < 3000; i++) begin
      int w, ch, r;
      bit [3:0] code;
      r = int'($urandom_range(0, 19));
      w = (r == 0) ? int'($urandom_range(5, 7)) : (r < 4 ? 0 : int'($urandom_range(1, 4)));
      ch = int'($urandom_range(0, 3));
      if ($urandom_range(0, 9) == 0) ch = 255;
      code = ($urandom_range(0, 2) == 0) ? {1'b1, 3'($urandom_range(0, 7))} :
             (($urandom_range(0, 15) == 0) ? 4'($urandom_range(1, 7)) : 4'b0000);
      if (w == 0 && $urandom_range(0, 3) != 0) code = 4'b0000;
      cyc(w, ch, 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
          1'($urandom_range(0, 2) == 0), code);
    end

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule